// File: doc/BRIEF.md
# Duration-Coded Framed Serial Transmitter

The block sends a short message as a one-bit level-select output, with each bit coded by how long the output stays at the mark level (1). A 1 bit holds the mark for a long count of clock cycles and a 0 bit for a short count. Every bit, the last one included, is followed by a separator: the opposite level (0), held for a fixed count. The level output could steer a choice between two operating points. The block only produces the timed level sequence.

A message is loaded word by word over a valid/ready input while the block is idle. The first word taken is the number of data words, and the data words follow. Once the last word is in, the block sends a frame: a delimiter word 0xAAAAAAAA, the word count, the data words in arrival order, and the delimiter again. Each word goes out from bit 31 down to bit 0. The three hold counts come from input ports. They are sampled once, when the frame starts.

Top module: `dur_frame_tx`

## Requirements
- R1: After reset, level_o is 0, busy_o is 0 and in_ready_o is 1. Whenever busy_o is 0, level_o rests at 0.
- R2: The first word accepted (in_valid_i and in_ready_o high at a clock edge) is the data word count. Counts above MAX_WORDS (8) are clamped to 8. On the cycle after the edge that accepts the last data word (or the count word, when the count is 0), busy_o and level_o are both 1.
- R3: in_ready_o is 0 whenever busy_o is 1. Words offered while busy are not consumed and do not alter the next message.
- R4: A 1 bit holds level_o at 1 for exactly the long hold count of cycles. A 0 bit holds it at 1 for exactly the short hold count.
- R5: Every bit, including the last, is followed by level_o at 0 for exactly the separator hold count of cycles.
- R6: The frame is 0xAAAAAAAA, then the clamped count zero-extended to 32 bits, then the data words in the order accepted, then 0xAAAAAAAA. Each word is sent from bit 31 down to bit 0.
- R7: The three hold inputs are sampled on the clock edge that starts the frame. Changing them during the frame has no effect on it.
- R8: busy_o stays 1 from the first mark cycle until the last separator ends, and falls on the edge that ends that separator. A new message can be loaded right after.
- R9: A hold input of 0 is treated as 1 cycle.
- R10: Hold sets of 400/200/200 and 200/100/25 (long/short/separator) are sent exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| long_hold_i | input | HOLD_W | Mark cycles for a 1 bit |
| short_hold_i | input | HOLD_W | Mark cycles for a 0 bit |
| gap_hold_i | input | HOLD_W | Separator cycles after each bit |
| in_word_i | input | WORD_W | Count word or data word |
| in_valid_i | input | 1 | Input word valid |
| in_ready_o | output | 1 | Input word accepted at this edge when valid |
| level_o | output | 1 | Level select: 1 mark, 0 separator/idle |
| busy_o | output | 1 | Frame in progress |

## Verification
Frame start is due one cycle after the edge that accepts the final word. The bench checks that edge by sampling busy_o and level_o right after it, and checks that busy_o is still 0 just before it. After that, every mark and separator must last exactly its programmed count. A monitor samples on the falling clock and records the length of each run of 1s and each run of 0s, ending the last 0 run when busy_o falls. Each frame is compared against a bit-by-bit expectation built from the frame layout, which confirms that the last separator is full length and that busy_o drops on the edge that ends it.

// File: rtl/dft_pkg.sv
package dft_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_MARK, TX_GAP} tx_state_e;
  localparam logic [31:0] FRAME_DELIM = 32'hAAAA_AAAA;
endpackage

// File: rtl/dft_msg_buf.sv
module dft_msg_buf #(
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = $clog2(MAX_WORDS + 1),
  parameter int IDX_W     = $clog2(MAX_WORDS + 3),
  parameter logic [WORD_W-1:0] DELIM = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              busy_i,
  output logic              done_o,
  output logic [IDX_W-1:0]  nwords_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] mem_q [MAX_WORDS];
  logic [CNT_W-1:0]  len_q, wcnt_q, len_in;
  logic              have_len_q, accept;

  assign ready_o = ~busy_i;
  assign accept  = valid_i & ready_o;

  always_comb begin
    if (word_i > WORD_W'(MAX_WORDS)) len_in = CNT_W'(MAX_WORDS);
    else                             len_in = word_i[CNT_W-1:0];
  end

  assign done_o = accept & (have_len_q ? (wcnt_q == len_q - 1'b1) : (len_in == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q      <= '0;
      wcnt_q     <= '0;
      have_len_q <= 1'b0;
    end else if (accept) begin
      if (!have_len_q) begin
        len_q      <= len_in;
        wcnt_q     <= '0;
        have_len_q <= (len_in != '0);
      end else begin
        wcnt_q <= wcnt_q + 1'b1;
        if (done_o) have_len_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (accept && have_len_q) mem_q[wcnt_q] <= word_i;
  end

  assign nwords_o = IDX_W'(len_q) + IDX_W'(3);

  // frame index 0 and last -> delimiter, 1 -> count, 2.. -> data
  always_comb begin
    rd_word_o = DELIM;
    if (rd_idx_i == IDX_W'(1)) rd_word_o = WORD_W'(len_q);
    for (int k = 0; k < MAX_WORDS; k++) begin
      if (rd_idx_i == IDX_W'(k + 2) && CNT_W'(k) < len_q) rd_word_o = mem_q[k];
    end
  end
endmodule

// File: rtl/dft_symbol_tx.sv
module dft_symbol_tx
  import dft_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HOLD_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] long_i,
  input  logic [HOLD_W-1:0] short_i,
  input  logic [HOLD_W-1:0] gap_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  nwords_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic              level_o,
  output logic              busy_o
);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(WORD_W - 1);

  tx_state_e         state_q;
  logic [HOLD_W-1:0] cnt_q, h1_q, h2_q, h3_q;
  logic [HOLD_W-1:0] eff_long, eff_short, eff_gap;
  logic [BIT_W-1:0]  bit_q, nxt_bit, bit_sel;
  logic [IDX_W-1:0]  widx_q;
  logic              level_q, last_bit, last_word, cur_val;

  assign eff_long  = (long_i  == '0) ? HOLD_W'(1) : long_i;
  assign eff_short = (short_i == '0) ? HOLD_W'(1) : short_i;
  assign eff_gap   = (gap_i   == '0) ? HOLD_W'(1) : gap_i;

  assign last_bit  = (bit_q == '0);
  assign last_word = (widx_q == nwords_i - 1'b1);
  assign nxt_bit   = last_bit ? TOP_BIT : bit_q - 1'b1;
  assign rd_idx_o  = (state_q == TX_GAP && last_bit) ? widx_q + 1'b1 : widx_q;
  assign bit_sel   = (state_q == TX_GAP) ? nxt_bit : bit_q;
  assign cur_val   = word_i[bit_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      h1_q    <= '0;
      h2_q    <= '0;
      h3_q    <= '0;
      bit_q   <= TOP_BIT;
      widx_q  <= '0;
      level_q <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          h1_q    <= eff_long;
          h2_q    <= eff_short;
          h3_q    <= eff_gap;
          cnt_q   <= cur_val ? eff_long : eff_short;
          state_q <= TX_MARK;
          level_q <= 1'b1;
        end
        TX_MARK: if (cnt_q == HOLD_W'(1)) begin
          state_q <= TX_GAP;
          level_q <= 1'b0;
          cnt_q   <= h3_q;
        end else cnt_q <= cnt_q - 1'b1;
        TX_GAP: if (cnt_q == HOLD_W'(1)) begin
          if (last_bit && last_word) begin
            state_q <= TX_IDLE;
            widx_q  <= '0;
            bit_q   <= TOP_BIT;
          end else begin
            bit_q   <= nxt_bit;
            if (last_bit) widx_q <= widx_q + 1'b1;
            cnt_q   <= cur_val ? h1_q : h2_q;
            level_q <= 1'b1;
            state_q <= TX_MARK;
          end
        end else cnt_q <= cnt_q - 1'b1;
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign level_o = level_q;
  assign busy_o  = (state_q != TX_IDLE);
endmodule

// File: rtl/dur_frame_tx.sv
module dur_frame_tx #(
  parameter int WORD_W    = 32,
  parameter int HOLD_W    = 16,
  parameter int MAX_WORDS = 8,
  parameter logic [WORD_W-1:0] DELIM = dft_pkg::FRAME_DELIM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HOLD_W-1:0] long_hold_i,
  input  logic [HOLD_W-1:0] short_hold_i,
  input  logic [HOLD_W-1:0] gap_hold_i,
  input  logic [WORD_W-1:0] in_word_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic              level_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = $clog2(MAX_WORDS + 3);

  logic              start;
  logic [IDX_W-1:0]  nwords, rd_idx;
  logic [WORD_W-1:0] rd_word;

  dft_msg_buf #(
    .WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .CNT_W(CNT_W), .IDX_W(IDX_W), .DELIM(DELIM)
  ) u_buf (
    .clk_i, .rst_ni,
    .word_i(in_word_i), .valid_i(in_valid_i), .ready_o(in_ready_o),
    .busy_i(busy_o), .done_o(start), .nwords_o(nwords),
    .rd_idx_i(rd_idx), .rd_word_o(rd_word)
  );

  dft_symbol_tx #(.WORD_W(WORD_W), .HOLD_W(HOLD_W), .IDX_W(IDX_W)) u_sym (
    .clk_i, .rst_ni, .start_i(start),
    .long_i(long_hold_i), .short_i(short_hold_i), .gap_i(gap_hold_i),
    .word_i(rd_word), .nwords_i(nwords), .rd_idx_o(rd_idx),
    .level_o, .busy_o
  );
endmodule

// File: rtl/dft_tx_checker.sv
module dft_tx_checker #(parameter int HOLD_W = 16) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              level_o,
  input logic              busy_o,
  input logic [HOLD_W-1:0] long_hold_i,
  input logic [HOLD_W-1:0] short_hold_i,
  input logic [HOLD_W-1:0] gap_hold_i
);
  logic [HOLD_W-1:0] lh_q, sh_q, gh_q, c1_q, c2_q, c3_q;
  logic [31:0]       mrun_q, grun_q;
  logic              busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lh_q <= '0; sh_q <= '0; gh_q <= '0;
      c1_q <= '0; c2_q <= '0; c3_q <= '0;
      mrun_q <= '0; grun_q <= '0; busy_q <= 1'b0;
    end else begin
      lh_q   <= long_hold_i;
      sh_q   <= short_hold_i;
      gh_q   <= gap_hold_i;
      busy_q <= busy_o;
      if (busy_o && !busy_q) begin
        c1_q <= (lh_q == '0) ? HOLD_W'(1) : lh_q;
        c2_q <= (sh_q == '0) ? HOLD_W'(1) : sh_q;
        c3_q <= (gh_q == '0) ? HOLD_W'(1) : gh_q;
      end
      mrun_q <= level_o ? mrun_q + 1 : '0;
      grun_q <= (level_o || !busy_o) ? '0 : grun_q + 1;
    end
  end

  a_r1_idle_rest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !level_o);
  a_r3_ready_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !in_ready_o);
  a_r4_mark_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $fell(level_o)) |-> (mrun_q == 32'(c1_q) || mrun_q == 32'(c2_q)));
  a_r5_gap_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(level_o) && grun_q != 0) |-> grun_q == 32'(c3_q));
  a_r5_last_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> grun_q == 32'(c3_q));
  a_r8_end_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(level_o));
endmodule

bind dur_frame_tx dft_tx_checker #(.HOLD_W(HOLD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_ready_o(in_ready_o),
  .level_o(level_o), .busy_o(busy_o),
  .long_hold_i(long_hold_i), .short_hold_i(short_hold_i), .gap_hold_i(gap_hold_i)
);

// File: tb/dur_frame_tx_bench.sv
`timescale 1ns/1ps
module dur_frame_tx_bench;
  localparam logic [31:0] DLM = 32'hAAAA_AAAA;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [15:0] long_hold_i = 16'd6, short_hold_i = 16'd3, gap_hold_i = 16'd2;
  logic [31:0] in_word_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o, level_o, busy_o;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] data_src [16];
  int mark_q[$], gap_q[$];
  int mrun = 0, grun = 0;
  bit prev_lvl = 1'b0, prev_busy = 1'b0, gap_open = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dur_frame_tx u_dur_frame_tx (
    .clk_i, .rst_ni, .long_hold_i, .short_hold_i, .gap_hold_i,
    .in_word_i, .in_valid_i, .in_ready_o, .level_o, .busy_o
  );

  // run-length monitor, sampled on the falling edge
  always @(negedge clk_i) begin
    if (prev_lvl && !level_o) begin mark_q.push_back(mrun); mrun = 0; end
    if (!prev_lvl && level_o && gap_open) begin gap_q.push_back(grun); grun = 0; end
    if (prev_busy && !busy_o) begin gap_q.push_back(grun); grun = 0; gap_open = 1'b0; end
    if (busy_o) begin
      if (level_o) begin mrun++; gap_open = 1'b1; end
      else grun++;
    end
    prev_lvl  = level_o;
    prev_busy = busy_o;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid_i = 1'b1;
    in_word_i  = w;
    @(posedge clk_i);
    #1 in_valid_i = 1'b0;
  endtask

  task automatic send_frame(input logic [31:0] len_word, input int ndata);
    mark_q.delete(); gap_q.delete();
    if (ndata == 0) begin
      chk(busy_o == 1'b0, "R2", "busy before final word", busy_o, 0);
      push(len_word);
    end else begin
      push(len_word);
      for (int i = 0; i < ndata - 1; i++) push(data_src[i]);
      chk(busy_o == 1'b0, "R2", "busy before final word", busy_o, 0);
      push(data_src[ndata-1]);
    end
    chk(busy_o && level_o, "R2", "busy&level after final word", {busy_o, level_o}, 3);
  endtask

  task automatic wait_idle();
    do @(negedge clk_i); while (busy_o);
    @(negedge clk_i);
  endtask

  task automatic check_frame(input string req, input int exp_n, input int c1,
                             input int c2, input int c3);
    logic [31:0] w;
    int nb, bad_m, bad_g, first;
    wait_idle();
    nb = 32 * (exp_n + 3);
    chk(mark_q.size() == nb && gap_q.size() == nb, req, "symbol count",
        mark_q.size(), nb);
    bad_m = 0; bad_g = 0; first = -1;
    if (mark_q.size() == nb && gap_q.size() == nb) begin
      for (int wi = 0; wi < exp_n + 3; wi++) begin
        if (wi == 0 || wi == exp_n + 2) w = DLM;
        else if (wi == 1) w = 32'(exp_n);
        else w = data_src[wi-2];
        for (int b = 31; b >= 0; b--) begin
          int k = wi * 32 + (31 - b);
          if (mark_q[k] != (w[b] ? c1 : c2)) begin
            if (first < 0) first = k;
            bad_m++;
          end
          if (gap_q[k] != c3) bad_g++;
        end
      end
    end
    chk(bad_m == 0, req, "mark lengths (R4/R6) mismatches",
        bad_m, 0);
    if (first >= 0) $display("  first mark mismatch at symbol %0d len=%0d", first, mark_q[first]);
    chk(bad_g == 0, req, "separator lengths (R5/R8) mismatches", bad_g, 0);
  endtask

  task automatic set_holds(input int a, input int b, input int c);
    long_hold_i = 16'(a); short_hold_i = 16'(b); gap_hold_i = 16'(c);
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk(level_o == 0, "R1", "level after reset", level_o, 0);
    chk(busy_o == 0, "R1", "busy after reset", busy_o, 0);
    chk(in_ready_o == 1, "R1", "ready after reset", in_ready_o, 1);
    @(posedge clk_i); #1;
  endtask

  task automatic t_basic();
    set_holds(6, 3, 2);
    data_src[0] = 32'h1234_5678; data_src[1] = 32'h8000_0001;
    send_frame(32'd2, 2);
    check_frame("R6", 2, 6, 3, 2);
    @(posedge clk_i); #1;
  endtask

  task automatic t_zero_len();
    set_holds(4, 2, 1);
    send_frame(32'd0, 0);
    check_frame("R6", 0, 4, 2, 1);
    @(posedge clk_i); #1;
  endtask

  task automatic t_clamp();
    set_holds(3, 1, 1);
    for (int i = 0; i < 8; i++) data_src[i] = 32'hC0DE_0000 + 32'(i * 7919);
    send_frame(32'd12, 8);
    check_frame("R2", 8, 3, 1, 1);
    @(posedge clk_i); #1;
  endtask

  task automatic t_ignore_busy();
    set_holds(5, 2, 3);
    data_src[0] = 32'hFFFF_0000;
    send_frame(32'd1, 1);
    in_valid_i = 1'b1; in_word_i = 32'd5;
    repeat (20) @(posedge clk_i);
    @(negedge clk_i);
    chk(in_ready_o == 0, "R3", "ready while busy", in_ready_o, 0);
    #1 in_valid_i = 1'b0;
    check_frame("R3", 1, 5, 2, 3);
    @(posedge clk_i); #1;
    data_src[0] = 32'h0F0F_3C3C;
    send_frame(32'd1, 1);
    check_frame("R3", 1, 5, 2, 3);
    @(posedge clk_i); #1;
  endtask

  task automatic t_hold_change();
    set_holds(7, 2, 4);
    data_src[0] = 32'hDEAD_BEEF;
    send_frame(32'd1, 1);
    set_holds(9, 9, 9);
    check_frame("R7", 1, 7, 2, 4);
    @(posedge clk_i); #1;
  endtask

  task automatic t_zero_hold();
    set_holds(0, 0, 0);
    data_src[0] = 32'h0000_00FF;
    send_frame(32'd1, 1);
    check_frame("R9", 1, 1, 1, 1);
    @(posedge clk_i); #1;
  endtask

  task automatic t_ratio(input int a, input int b, input int c);
    set_holds(a, b, c);
    send_frame(32'd0, 0);
    check_frame("R10", 0, a, b, c);
    @(posedge clk_i); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_basic();
    t_zero_len();
    t_clamp();
    t_ignore_busy();
    t_hold_change();
    t_zero_hold();
    t_ratio(400, 200, 200);
    t_ratio(200, 100, 25);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule